// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits between a 32-bit bus slave port and an on-chip flash array. In read mode it forwards each read to the array and hands the array word back. It also watches every bus write. A command is three ordered word writes, each with a fixed address and data value. When the third write names an erase or program operation, the controller enters automatic operation. In that mode a cycle counter models how long the operation takes, the busy flag stays high, and array reads are blocked.

The third write can instead ask for identification. The controller then stays in a terminated ID state and returns an identity word until a software reset write arrives. A full-word write of 0x0000_00F0 to any address is the software reset. It cancels any partly entered command. No bus write can end automatic operation: such writes are dropped and set a sticky error flag. Only the active-low hardware reset clears that flag or cuts an operation short.

The expected address and data of each step, the operation codes and lengths, the status word and the identity word are all parameters.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After hardware reset the block is in read mode: busy_o=0, err_o=0, and reads return array data.
- R2: In read mode, while rd_i is high, array_rd_o=1, array_addr_o=addr_i and rdata_o=array_rdata_i, all in the same cycle.
- R3: A command is three full-word writes in this order: (0x555, 0xAA), then (0x2AA, 0x55), then a write to 0x555 whose data selects the command. 0x10 selects erase and 0xA0 selects program; either one starts automatic operation.
- R4: busy_o rises in the cycle after the third write and stays high for exactly ERASE_CYCLES (erase) or PROG_CYCLES (program) cycles. The block then returns to read mode.
- R5: While busy_o is high, a read returns STATUS_WORD and array_rd_o stays 0.
- R6: A write during automatic operation is ignored, including a 0xF0 write, so the busy length does not change. Such a write sets err_o one cycle later, and err_o stays set until hardware reset.
- R7: In the second or third step, a write with the wrong address or data, or a third-step code other than 0x10/0xA0/0x90, abandons the command and returns to read mode. Recognition must then restart from step one.
- R8: A write whose byte strobes are not all four set (be_i != 4'hF) never counts as a command step. At any step it is treated as an out-of-order write.
- R9: A full-word write of 0x0000_00F0 to any address, outside automatic operation, returns the block to read mode and cancels a partly entered command.
- R10: Third-step code 0x90 enters ID mode. In ID mode reads return ID_WORD with array_rd_o=0, every write other than the R9 reset is ignored, and only the R9 reset returns the block to read mode.
- R11: Asserting rst_ni during automatic operation drops busy_o at once and restores read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | AW | Bus address |
| wdata_i | input | 32 | Bus write data |
| be_i | input | 4 | Byte strobes of the write |
| rdata_o | output | 32 | Read data returned to the bus |
| array_rd_o | output | 1 | Read enable to the flash array |
| array_addr_o | output | AW | Address to the flash array |
| array_rdata_i | input | 32 | Data from the flash array |
| busy_o | output | 1 | Automatic operation in progress |
| err_o | output | 1 | Sticky flag: a write arrived during automatic operation |

## Verification
The hardest cases to reach are the ones where a bad write lands deep in a sequence: a wrong second or third step, or a partial-strobe write at one exact position, after the earlier steps were correct. The bench reaches them with sweeps. It runs every third-step data byte and every second-step data byte after a correct prefix. It also puts each of the fifteen partial strobe patterns at each of the three positions. For every case it works out from the code table whether busy must appear, for how long, or whether the ID word must be returned. A second hard case is a write that arrives while the block is busy. The bench issues that write back-to-back with the command so it is certain to land inside the busy window, then checks the shortened remaining count and the sticky flag.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE_READ,
    ST_CYCLE1_OK,
    ST_CYCLE2_OK,
    ST_ID_READ,
    ST_AUTO_BUSY
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_ERASE,
    OP_PROG,
    OP_ID
  } op_e;

  typedef struct packed {
    logic full;
    logic is_rst;
    logic step1;
    logic step2;
    op_e  op;
  } wr_class_t;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int unsigned    AW        = 12,
  parameter logic [AW-1:0]  ADDR1     = 12'h555,
  parameter logic [31:0]    DATA1     = 32'h0000_00AA,
  parameter logic [AW-1:0]  ADDR2     = 12'h2AA,
  parameter logic [31:0]    DATA2     = 32'h0000_0055,
  parameter logic [AW-1:0]  ADDR3     = 12'h555,
  parameter logic [31:0]    CMD_ERASE = 32'h0000_0010,
  parameter logic [31:0]    CMD_PROG  = 32'h0000_00A0,
  parameter logic [31:0]    CMD_ID    = 32'h0000_0090,
  parameter logic [31:0]    RST_DATA  = 32'h0000_00F0
) (
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic [3:0]    be_i,
  output wr_class_t     cls_o
);

  logic full;
  assign full = &be_i;

  always_comb begin
    cls_o.full   = full;
    cls_o.is_rst = full && (wdata_i == RST_DATA);
    cls_o.step1  = full && (addr_i == ADDR1) && (wdata_i == DATA1);
    cls_o.step2  = full && (addr_i == ADDR2) && (wdata_i == DATA2);
    cls_o.op     = OP_NONE;
    if (full && (addr_i == ADDR3)) begin
      if (wdata_i == CMD_ERASE)     cls_o.op = OP_ERASE;
      else if (wdata_i == CMD_PROG) cls_o.op = OP_PROG;
      else if (wdata_i == CMD_ID)   cls_o.op = OP_ID;
    end
  end

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 40,
  parameter int unsigned PROG_CYCLES  = 12,
  localparam int unsigned MAXLEN = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
  localparam int unsigned CW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  op_e  op_i,
  output logic done_o
);

  localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYCLES - 1);
  localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (op_i == OP_ERASE) ? ERASE_LAST : PROG_LAST;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  wr_class_t  cls_i,
  input  logic       done_i,
  output seq_state_e state_o,
  output logic       load_o,
  output op_e        op_o,
  output logic       err_o
);

  seq_state_e state_q, state_d;
  logic       err_q;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    op_o    = cls_i.op;
    unique case (state_q)
      ST_IDLE_READ: if (wr_i && cls_i.step1 && !cls_i.is_rst) state_d = ST_CYCLE1_OK;
      ST_CYCLE1_OK: if (wr_i) state_d = cls_i.step2 ? ST_CYCLE2_OK : ST_IDLE_READ;
      ST_CYCLE2_OK: begin
        if (wr_i) begin
          unique case (cls_i.op)
            OP_ERASE, OP_PROG: begin
              state_d = ST_AUTO_BUSY;
              load_o  = 1'b1;
            end
            OP_ID:   state_d = ST_ID_READ;
            default: state_d = ST_IDLE_READ;
          endcase
        end
      end
      ST_ID_READ:   if (wr_i && cls_i.is_rst) state_d = ST_IDLE_READ;
      ST_AUTO_BUSY: if (done_i) state_d = ST_IDLE_READ;
      default:      state_d = ST_IDLE_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE_READ;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_AUTO_BUSY && wr_i) err_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW          = 12,
  parameter logic [31:0] STATUS_WORD = 32'h0000_0080,
  parameter logic [31:0] ID_WORD     = 32'h0098_00C3
) (
  input  seq_state_e    state_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   array_rdata_i,
  output logic [31:0]   rdata_o,
  output logic          array_rd_o,
  output logic [AW-1:0] array_addr_o
);

  logic blocked;
  assign blocked      = (state_i == ST_AUTO_BUSY) || (state_i == ST_ID_READ);
  assign array_rd_o   = rd_i && !blocked;
  assign array_addr_o = addr_i;

  always_comb begin
    unique case (state_i)
      ST_AUTO_BUSY: rdata_o = STATUS_WORD;
      ST_ID_READ:   rdata_o = ID_WORD;
      default:      rdata_o = array_rdata_i;
    endcase
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned    AW           = 12,
  parameter logic [AW-1:0]  ADDR1        = 12'h555,
  parameter logic [31:0]    DATA1        = 32'h0000_00AA,
  parameter logic [AW-1:0]  ADDR2        = 12'h2AA,
  parameter logic [31:0]    DATA2        = 32'h0000_0055,
  parameter logic [AW-1:0]  ADDR3        = 12'h555,
  parameter logic [31:0]    CMD_ERASE    = 32'h0000_0010,
  parameter logic [31:0]    CMD_PROG     = 32'h0000_00A0,
  parameter logic [31:0]    CMD_ID       = 32'h0000_0090,
  parameter logic [31:0]    RST_DATA     = 32'h0000_00F0,
  parameter int unsigned    ERASE_CYCLES = 40,
  parameter int unsigned    PROG_CYCLES  = 12,
  parameter logic [31:0]    STATUS_WORD  = 32'h0000_0080,
  parameter logic [31:0]    ID_WORD      = 32'h0098_00C3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic [3:0]    be_i,
  output logic [31:0]   rdata_o,
  output logic          array_rd_o,
  output logic [AW-1:0] array_addr_o,
  input  logic [31:0]   array_rdata_i,
  output logic          busy_o,
  output logic          err_o
);

  wr_class_t  cls;
  seq_state_e state;
  logic       load, done;
  op_e        op;

  flash_cmd_decode #(
    .AW(AW), .ADDR1(ADDR1), .DATA1(DATA1), .ADDR2(ADDR2), .DATA2(DATA2),
    .ADDR3(ADDR3), .CMD_ERASE(CMD_ERASE), .CMD_PROG(CMD_PROG),
    .CMD_ID(CMD_ID), .RST_DATA(RST_DATA)
  ) u_decode (
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .be_i   (be_i),
    .cls_o  (cls)
  );

  flash_seq_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .cls_i  (cls),
    .done_i (done),
    .state_o(state),
    .load_o (load),
    .op_o   (op),
    .err_o  (err_o)
  );

  flash_busy_timer #(
    .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .op_i  (op),
    .done_o(done)
  );

  flash_read_mux #(
    .AW(AW), .STATUS_WORD(STATUS_WORD), .ID_WORD(ID_WORD)
  ) u_rmux (
    .state_i      (state),
    .rd_i         (rd_i),
    .addr_i       (addr_i),
    .array_rdata_i(array_rdata_i),
    .rdata_o      (rdata_o),
    .array_rd_o   (array_rd_o),
    .array_addr_o (array_addr_o)
  );

  assign busy_o = (state == ST_AUTO_BUSY);

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int unsigned AW          = 12,
  parameter logic [31:0] RST_DATA    = 32'h0000_00F0,
  parameter logic [31:0] STATUS_WORD = 32'h0000_0080
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          rd_i,
  input logic [AW-1:0] addr_i,
  input logic [31:0]   wdata_i,
  input logic [3:0]    be_i,
  input logic [31:0]   rdata_o,
  input logic          array_rd_o,
  input logic [AW-1:0] array_addr_o,
  input logic [31:0]   array_rdata_i,
  input logic          busy_o,
  input logic          err_o
);

  a_r5_status_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_i) |-> (rdata_o == STATUS_WORD && !array_rd_o));

  a_r2_array_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    array_rd_o |-> (rdata_o == array_rdata_i && array_addr_o == addr_i && !busy_o));

  a_r6_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_i) |=> err_o);

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r4_busy_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(wr_i) && $past(be_i) == 4'hF));

  a_r8_partial_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && be_i != 4'hF && !busy_o) |=> !busy_o);

  a_r9_reset_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && be_i == 4'hF && wdata_i == RST_DATA && !busy_o) |=> !busy_o);

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
  .AW(AW), .RST_DATA(RST_DATA), .STATUS_WORD(STATUS_WORD)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .be_i         (be_i),
  .rdata_o      (rdata_o),
  .array_rd_o   (array_rd_o),
  .array_addr_o (array_addr_o),
  .array_rdata_i(array_rdata_i),
  .busy_o       (busy_o),
  .err_o        (err_o)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;

  localparam int unsigned AW    = 12;
  localparam int unsigned ERASE = 6;
  localparam int unsigned PROG  = 3;
  localparam logic [31:0] STAT  = 32'h0000_0080;
  localparam logic [31:0] IDW   = 32'h0098_00C3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0, rd_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [3:0]    be_i = '0;
  logic [31:0]   rdata_o, array_rdata_i;
  logic          array_rd_o, busy_o, err_o;
  logic [AW-1:0] array_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  assign array_rdata_i = {4'hC, array_addr_o, 4'h3, array_addr_o};

  flash_cmd_ctrl #(
    .AW(AW), .ERASE_CYCLES(ERASE), .PROG_CYCLES(PROG),
    .STATUS_WORD(STAT), .ID_WORD(IDW)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i), .rdata_o(rdata_o),
    .array_rd_o(array_rd_o), .array_addr_o(array_addr_o),
    .array_rdata_i(array_rdata_i), .busy_o(busy_o), .err_o(err_o)
  );

  function automatic logic [31:0] arr_word(logic [AW-1:0] a);
    return {4'hC, a, 4'h3, a};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the next negedge
  task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d, logic [3:0] be);
    wr_i = 1'b1; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk_i);
    wr_i = 1'b0; be_i = '0;
  endtask

  task automatic bus_rd(logic [AW-1:0] a, output logic [31:0] d, output logic ard);
    rd_i = 1'b1; addr_i = a;
    #1;
    d = rdata_o; ard = array_rd_o;
    rd_i = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(12'h555, 32'hAA, 4'hF);
    bus_wr(12'h2AA, 32'h55, 4'hF);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy_o && n < 100) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic hw_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic expect_read_mode(string req, logic [AW-1:0] a);
    logic [31:0] d;
    logic ard;
    chk(req, 32'(busy_o), 32'd0);
    bus_rd(a, d, ard);
    chk(req, d, arr_word(a));
    chk(req, 32'(ard), 32'd1);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] d;
    logic ard;

    @(negedge clk_i);
    hw_reset();

    // R1 reset state
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 err", 32'(err_o), 32'd0);
    expect_read_mode("R1 read", 12'h123);

    // R2 read passthrough sweep
    for (int i = 0; i < 32; i++) begin
      bus_rd(AW'(i * 131), d, ard);
      chk("R2 rdata", d, arr_word(AW'(i * 131)));
      chk("R2 array_rd", 32'(ard), 32'd1);
    end

    // R3/R4 erase and program lengths
    unlock();
    bus_wr(12'h555, 32'h10, 4'hF);
    busy_len(n);
    chk("R4 erase len", 32'(n), 32'(ERASE));
    expect_read_mode("R4 return", 12'h0AB);
    unlock();
    bus_wr(12'h555, 32'hA0, 4'hF);
    busy_len(n);
    chk("R3 program len", 32'(n), 32'(PROG));

    // R5 status while busy
    unlock();
    bus_wr(12'h555, 32'h10, 4'hF);
    bus_rd(12'h001, d, ard);
    chk("R5 status", d, STAT);
    chk("R5 array_rd", 32'(ard), 32'd0);
    busy_len(n);

    // R6 write during busy ignored, err sticky
    unlock();
    bus_wr(12'h555, 32'h10, 4'hF);
    bus_wr(12'h0FF, 32'hF0, 4'hF);
    chk("R6 err set", 32'(err_o), 32'd1);
    busy_len(n);
    chk("R6 busy len unchanged", 32'(n), 32'(ERASE - 1));
    chk("R6 err sticky", 32'(err_o), 32'd1);
    unlock();
    chk("R6 err still", 32'(err_o), 32'd1);
    bus_wr(12'h000, 32'hF0, 4'hF);
    hw_reset();
    chk("R6 err cleared", 32'(err_o), 32'd0);

    // R11 hardware reset during busy
    unlock();
    bus_wr(12'h555, 32'h10, 4'hF);
    chk("R11 busy before", 32'(busy_o), 32'd1);
    rst_ni = 1'b0;
    #1;
    chk("R11 busy drop", 32'(busy_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    expect_read_mode("R11 read mode", 12'h456);

    // R7/R10 third-step data sweep
    for (int v = 0; v < 256; v++) begin
      unlock();
      bus_wr(12'h555, 32'(v), 4'hF);
      if (v == 32'h10 || v == 32'hA0) begin
        busy_len(n);
        chk("R3 sweep len", 32'(n), (v == 32'h10) ? 32'(ERASE) : 32'(PROG));
      end else if (v == 32'h90) begin
        chk("R10 no busy", 32'(busy_o), 32'd0);
        bus_rd(12'h010, d, ard);
        chk("R10 id word", d, IDW);
        chk("R10 array_rd", 32'(ard), 32'd0);
        unlock();
        bus_wr(12'h555, 32'h10, 4'hF);
        chk("R10 writes ignored", 32'(busy_o), 32'd0);
        bus_rd(12'h010, d, ard);
        chk("R10 still id", d, IDW);
        bus_wr(12'h3C3, 32'hF0, 4'hF);
        expect_read_mode("R10 exit", 12'h010);
      end else begin
        expect_read_mode("R7 bad step3", AW'(v));
      end
    end

    // R7 second-step sweep: wrong data then a would-be third step
    for (int v = 0; v < 256; v++) begin
      if (v != 32'h55) begin
        bus_wr(12'h555, 32'hAA, 4'hF);
        bus_wr(12'h2AA, 32'(v), 4'hF);
        bus_wr(12'h555, 32'h10, 4'hF);
        chk("R7 bad step2", 32'(busy_o), 32'd0);
      end
    end
    // R7 wrong addresses
    bus_wr(12'h555, 32'hAA, 4'hF);
    bus_wr(12'h2AB, 32'h55, 4'hF);
    bus_wr(12'h555, 32'h10, 4'hF);
    chk("R7 bad addr2", 32'(busy_o), 32'd0);
    unlock();
    bus_wr(12'h554, 32'h10, 4'hF);
    expect_read_mode("R7 bad addr3", 12'h554);

    // R8 partial strobes at each step
    for (int p = 1; p <= 3; p++) begin
      for (int b = 0; b < 15; b++) begin
        bus_wr(12'h555, 32'hAA, (p == 1) ? 4'(b) : 4'hF);
        bus_wr(12'h2AA, 32'h55, (p == 2) ? 4'(b) : 4'hF);
        bus_wr(12'h555, 32'h10, (p == 3) ? 4'(b) : 4'hF);
        chk("R8 partial strobe", 32'(busy_o), 32'd0);
        bus_wr(12'h000, 32'hF0, 4'hF);
      end
    end
    unlock();
    bus_wr(12'h555, 32'hA0, 4'hF);
    busy_len(n);
    chk("R8 full after partial", 32'(n), 32'(PROG));

    // R9 software reset cancels partial commands
    bus_wr(12'h555, 32'hAA, 4'hF);
    bus_wr(12'h7FF, 32'hF0, 4'hF);
    bus_wr(12'h2AA, 32'h55, 4'hF);
    bus_wr(12'h555, 32'h10, 4'hF);
    chk("R9 cancel after step1", 32'(busy_o), 32'd0);
    unlock();
    bus_wr(12'h7FF, 32'hF0, 4'hF);
    bus_wr(12'h555, 32'h10, 4'hF);
    chk("R9 cancel after step2", 32'(busy_o), 32'd0);
    unlock();
    bus_wr(12'h555, 32'hF0, 4'hF);
    expect_read_mode("R9 third-step reset", 12'h222);
    bus_wr(12'h123, 32'hF0, 4'hF);
    expect_read_mode("R9 idle reset", 12'h321);
    chk("R9 err untouched", 32'(err_o), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule